// File: doc/BRIEF.md
# Serial Test Vector Controller

This block sequences one test of a circuit under test through an inserted test point. A short serial stream loads a latency setting, a stimulus vector and an expected response word. The controller then pulses a mode toggle that switches the test point into test mode. After one settling cycle it drives the stimulus onto a parallel test-data bus. It waits as many cycles as the circuit's pipeline needs, samples the response through a fan-out tap and compares it with the expected word. A second toggle pulse returns the test point to functional mode. The verdict and the captured response then leave on a serial line.

The test-data bus stays at zero at all times outside test mode. This lets the bus join the functional path through a simple merge instead of a select. The mode is changed by single-cycle toggle pulses rather than by a held level. A mismatch flag stays set after the run until the next test is started, so a slow observer can still read the result.

Top module: `tvec_ctrl`

## Requirements
- R1: A `start_i` pulse while idle is accepted, and `busy_o` rises in the next cycle. In each of the following LAT_W+VEC_W+RSP_W cycles one bit is taken from `ser_in_i`, most significant bit first. The stream is the latency field (LAT_W bits), then the vector (VEC_W bits), then the expected word (RSP_W bits).
- R2: `mode_tgl_o` pulses for exactly one cycle in the cycle after the last load bit. It pulses once more in the cycle after the capture cycle. There are exactly two pulses per run.
- R3: The vector appears on `tdata_o` two cycles after the entry toggle cycle, which leaves one settling cycle between them.
- R4: `tdata_o` is zero in every cycle outside the span between the two toggle pulses. Inside that span it holds the loaded vector constant from its first cycle through the capture cycle.
- R5: With latency L, `rsp_i` is sampled in the cycle L cycles after the vector first appears. A circuit of L register stages is therefore captured correctly, while one of L+1 stages yields its idle response.
- R6: A latency field of 0 behaves exactly as a latency of 1.
- R7: In the cycle after the exit toggle, `so_valid_o` rises and stays high for RSP_W+1 cycles. It first carries the pass bit on `ser_out_o` (1 = response equal to the expected word), then the captured response MSB first. `ser_out_o` is 0 while `so_valid_o` is low.
- R8: `fail_o` goes high after a capture that mismatches. It stays high through idle until the next accepted start, and it is low in the cycle after that start.
- R9: `start_i` pulses while `busy_o` is high have no effect on the sequence, its timing or its result.
- R10: After reset, the controller is idle and every output is low or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted only while idle |
| ser_in_i | input | 1 | Serial load data (latency, vector, expected word) |
| ser_out_o | output | 1 | Serial result data (pass bit, captured response) |
| so_valid_o | output | 1 | High while `ser_out_o` carries result bits |
| mode_tgl_o | output | 1 | Single-cycle toggle pulse for the test point's mode flop |
| tdata_o | output | VEC_W | Parallel test data toward the circuit under test |
| rsp_i | input | RSP_W | Parallel response tap from the circuit under test |
| busy_o | output | 1 | High from the cycle after an accepted start until unload ends |
| fail_o | output | 1 | Sticky mismatch flag |

## Verification
A wrong state or counter value shows up at the ports within one run. A miscount in loading or settling moves the entry toggle or the first vector cycle away from its expected cycle. A wrong latency count makes a deliberately deeper model circuit pass, or a matching one fail, and this is visible in the first serial result bit. A stuck mode or data register shows as a third toggle, as a non-zero bus outside the toggle span, or as `fail_o` failing to clear in the cycle after the next start.

// File: rtl/tvc_pkg.sv
package tvc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_ENTER,
        ST_APPLY,
        ST_WAIT,
        ST_CAPTURE,
        ST_EXIT,
        ST_UNLOAD
    } tvc_state_e;

endpackage

// File: rtl/tvc_shift.sv
module tvc_shift #(
    parameter int W = 20
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         shift_i,
    input  logic         ser_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load_i) begin
            sr_d = load_val_i;
        end else if (shift_i) begin
            sr_d = {sr_q[W-2:0], ser_i};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign q_o = sr_q;

endmodule

// File: rtl/tvc_timer.sv
module tvc_timer #(
    parameter int CW = 5
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          dec_i,
    output logic          done_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // last cycle of the current span
    assign done_o = (cnt_q <= CW'(1));

endmodule

// File: rtl/tvc_cmp.sv
module tvc_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] rsp_i,
    input  logic [W-1:0] exp_i,
    output logic         mismatch_o
);

    logic [W-1:0] diff;

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign diff[b] = rsp_i[b] ^ exp_i[b];
    end

    assign mismatch_o = |diff;

endmodule

// File: rtl/tvec_ctrl.sv
module tvec_ctrl #(
    parameter int VEC_W = 8,
    parameter int RSP_W = 8,
    parameter int LAT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             ser_in_i,
    output logic             ser_out_o,
    output logic             so_valid_o,
    output logic             mode_tgl_o,
    output logic [VEC_W-1:0] tdata_o,
    input  logic [RSP_W-1:0] rsp_i,
    output logic             busy_o,
    output logic             fail_o
);

    import tvc_pkg::*;

    localparam int LOAD_BITS = LAT_W + VEC_W + RSP_W;
    localparam int UNL_BITS  = RSP_W + 1;
    localparam int PAD_BITS  = LOAD_BITS - UNL_BITS;
    localparam int CNT_RAW   = $clog2(LOAD_BITS + 1);
    localparam int CNT_W     = (CNT_RAW > LAT_W) ? CNT_RAW : LAT_W;

    typedef struct packed {
        tvc_state_e       state;
        logic             tgl;
        logic             fail;
        logic [VEC_W-1:0] tdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [LOAD_BITS-1:0] sr_q;
    logic [LOAD_BITS-1:0] sr_val;
    logic                 sr_shift, sr_load, sr_ser;
    logic                 tm_load, tm_dec, tm_done;
    logic [CNT_W-1:0]     tm_val;
    logic                 mism;

    logic [LAT_W-1:0]     lat_fld;
    logic [VEC_W-1:0]     vec_fld;
    logic [RSP_W-1:0]     exp_fld;
    logic [CNT_W-1:0]     lat_eff;

    assign lat_fld = sr_q[LOAD_BITS-1 -: LAT_W];
    assign vec_fld = sr_q[RSP_W +: VEC_W];
    assign exp_fld = sr_q[RSP_W-1:0];
    assign lat_eff = (lat_fld == '0) ? CNT_W'(1) : CNT_W'(lat_fld);

    tvc_shift #(.W(LOAD_BITS)) u_shift (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .shift_i    (sr_shift),
        .ser_i      (sr_ser),
        .load_i     (sr_load),
        .load_val_i (sr_val),
        .q_o        (sr_q)
    );

    tvc_timer #(.CW(CNT_W)) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (tm_load),
        .load_val_i (tm_val),
        .dec_i      (tm_dec),
        .done_o     (tm_done)
    );

    tvc_cmp #(.W(RSP_W)) u_cmp (
        .rsp_i      (rsp_i),
        .exp_i      (exp_fld),
        .mismatch_o (mism)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.tgl = 1'b0;
        sr_shift  = 1'b0;
        sr_load   = 1'b0;
        sr_val    = '0;
        sr_ser    = (ctl_q.state == ST_LOAD) ? ser_in_i : 1'b0;
        tm_load   = 1'b0;
        tm_val    = '0;
        tm_dec    = 1'b0;

        unique case (ctl_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.state = ST_LOAD;
                    ctl_d.fail  = 1'b0;
                    tm_load     = 1'b1;
                    tm_val      = CNT_W'(LOAD_BITS);
                end
            end
            ST_LOAD: begin
                sr_shift = 1'b1;
                tm_dec   = 1'b1;
                if (tm_done) begin
                    ctl_d.state = ST_ENTER;
                    ctl_d.tgl   = 1'b1;
                    tm_load     = 1'b1;
                    tm_val      = CNT_W'(2);
                end
            end
            ST_ENTER: begin
                tm_dec = 1'b1;
                if (tm_done) begin
                    ctl_d.state = ST_APPLY;
                    ctl_d.tdata = vec_fld;
                    tm_load     = 1'b1;
                    tm_val      = lat_eff;
                end
            end
            ST_APPLY, ST_WAIT: begin
                tm_dec = 1'b1;
                ctl_d.state = tm_done ? ST_CAPTURE : ST_WAIT;
            end
            ST_CAPTURE: begin
                sr_load     = 1'b1;
                sr_val      = {~mism, rsp_i, {PAD_BITS{1'b0}}};
                ctl_d.fail  = ctl_q.fail | mism;
                ctl_d.tdata = '0;
                ctl_d.tgl   = 1'b1;
                ctl_d.state = ST_EXIT;
            end
            ST_EXIT: begin
                tm_load     = 1'b1;
                tm_val      = CNT_W'(UNL_BITS);
                ctl_d.state = ST_UNLOAD;
            end
            ST_UNLOAD: begin
                sr_shift = 1'b1;
                tm_dec   = 1'b1;
                if (tm_done) begin
                    ctl_d.state = ST_IDLE;
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
                ctl_d.tdata = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '{state: ST_IDLE, tgl: 1'b0, fail: 1'b0, tdata: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign so_valid_o = (ctl_q.state == ST_UNLOAD);
    assign ser_out_o  = so_valid_o & sr_q[LOAD_BITS-1];
    assign mode_tgl_o = ctl_q.tgl;
    assign tdata_o    = ctl_q.tdata;
    assign busy_o     = (ctl_q.state != ST_IDLE);
    assign fail_o     = ctl_q.fail;

endmodule

// File: rtl/tvec_ctrl_chk.sv
module tvec_ctrl_chk #(
    parameter int VEC_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic             busy_o,
    input logic             fail_o,
    input logic             mode_tgl_o,
    input logic             so_valid_o,
    input logic [VEC_W-1:0] tdata_o
);

    // R2
    tgl_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_tgl_o |=> !mode_tgl_o);

    // R4
    tgl_no_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_tgl_o |-> (tdata_o == '0));

    // R4
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> ((tdata_o == '0) && !so_valid_o && !mode_tgl_o));

    // R1
    start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && start_i) |=> busy_o);

    // R8
    fail_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fail_o && !(start_i && !busy_o)) |=> fail_o);

    // R8
    fail_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && start_i) |=> !fail_o);

    // R7
    unload_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        so_valid_o |-> busy_o);

endmodule

bind tvec_ctrl tvec_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .fail_o     (fail_o),
    .mode_tgl_o (mode_tgl_o),
    .so_valid_o (so_valid_o),
    .tdata_o    (tdata_o)
);

// File: tb/tvec_ctrl_tb.sv
module tvec_ctrl_tb;

    localparam int VW = 8;
    localparam int RW = 8;
    localparam int LW = 4;
    localparam int NB = LW + VW + RW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          si = 1'b0;
    logic          so, so_valid, tgl, busy, fail;
    logic [VW-1:0] tdata;
    logic [RW-1:0] rsp;

    always #4 clk = ~clk;

    tvec_ctrl #(.VEC_W(VW), .RSP_W(RW), .LAT_W(LW)) u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .start_i    (start),
        .ser_in_i   (si),
        .ser_out_o  (so),
        .so_valid_o (so_valid),
        .mode_tgl_o (tgl),
        .tdata_o    (tdata),
        .rsp_i      (rsp),
        .busy_o     (busy),
        .fail_o     (fail)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // model circuit: a pipeline of 'depth' registers behind a fixed mapping
    function automatic logic [RW-1:0] cut_fn(input logic [VW-1:0] x);
        return {x[3:0], x[7:4]} ^ 8'h5A;
    endfunction

    logic [RW-1:0] pipe [0:16];
    int            depth = 1;
    logic [RW-1:0] flip = '0;

    always @(posedge clk) begin
        pipe[0] <= cut_fn(tdata);
        for (int i = 1; i < 17; i++) pipe[i] <= pipe[i-1];
    end
    always_comb rsp = pipe[depth-1] ^ flip;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    typedef struct {
        logic          pass;
        logic [RW-1:0] rsp;
        int            t_enter;
        int            t_apply;
        int            t_exit;
        logic [VW-1:0] vec;
        string         tag;
    } exp_t;

    exp_t sbq[$];

    // monitor
    int            tg_cyc[$];
    int            apply_cyc = -1;
    logic [VW-1:0] seen_vec = '0;
    bit            in_test = 1'b0;
    int            viol = 0;
    logic [RW:0]   col = '0;
    int            ncol = 0;

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (tgl) begin
                    tg_cyc.push_back(cyc);
                    in_test = !in_test;
                end
                if (!in_test && tdata != '0) viol++;
                if (tdata != '0) begin
                    if (apply_cyc < 0) begin
                        apply_cyc = cyc;
                        seen_vec  = tdata;
                    end else if (tdata != seen_vec) begin
                        viol++;
                    end
                end
                if (!so_valid && so) viol++;
                if (so_valid) begin
                    col = {col[RW-1:0], so};
                    ncol++;
                end else if (ncol > 0) begin
                    if (sbq.size() == 0) begin
                        chk(1'b0, "R7", "unexpected result stream", ncol, 0);
                    end else begin
                        exp_t e;
                        e = sbq.pop_front();
                        chk(ncol == RW + 1, "R7", "result bit count", ncol, RW + 1);
                        chk(col[RW] == e.pass, e.tag, "pass bit", col[RW], e.pass);
                        chk(col[RW-1:0] == e.rsp, e.tag, "captured response",
                            col[RW-1:0], e.rsp);
                        chk(tg_cyc.size() == 2, "R2", "toggle count", tg_cyc.size(), 2);
                        chk(tg_cyc.size() > 0 && tg_cyc[0] == e.t_enter, "R1",
                            "entry toggle cycle", (tg_cyc.size() > 0) ? tg_cyc[0] : -1,
                            e.t_enter);
                        chk(apply_cyc == e.t_apply, "R3", "vector first cycle",
                            apply_cyc, e.t_apply);
                        chk(seen_vec == e.vec, "R4", "applied vector", seen_vec, e.vec);
                        chk(tg_cyc.size() > 1 && tg_cyc[1] == e.t_exit, "R5",
                            "exit toggle cycle", (tg_cyc.size() > 1) ? tg_cyc[1] : -1,
                            e.t_exit);
                        chk(viol == 0, "R4", "bus or serial line active out of span",
                            viol, 0);
                    end
                    tg_cyc.delete();
                    apply_cyc = -1;
                    viol      = 0;
                    ncol      = 0;
                    col       = '0;
                end
            end
        end
    end

    // driver: pushes the expected item, then plays the load stream
    task automatic run_test(input int lat, input logic [VW-1:0] vec,
                            input logic [RW-1:0] expw, input int d,
                            input logic [RW-1:0] fl, input bit extra_start,
                            input string tag);
        exp_t          e;
        int            leff;
        int            s;
        int            guard;
        logic [RW-1:0] cap;
        logic [NB-1:0] w;
        leff  = (lat == 0) ? 1 : lat;
        depth = d;
        flip  = fl;
        cap   = (d <= leff) ? (cut_fn(vec) ^ fl) : (cut_fn('0) ^ fl);
        e.pass    = (cap == expw);
        e.rsp     = cap;
        e.vec     = vec;
        e.tag     = tag;
        w         = {LW'(lat), vec, expw};
        @(negedge clk);
        s         = cyc;
        start     = 1'b1;
        e.t_enter = s + NB + 1;
        e.t_apply = s + NB + 3;
        e.t_exit  = s + NB + 3 + leff + 1;
        sbq.push_back(e);
        for (int k = NB - 1; k >= 0; k--) begin
            @(negedge clk);
            start = 1'b0;
            si    = w[k];
            if (k == NB - 1) begin
                chk(busy == 1'b1, "R1", "busy after start", busy, 1);
                chk(fail == 1'b0, "R8", "flag cleared by start", fail, 0);
            end
        end
        @(negedge clk);
        si = 1'b0;
        if (extra_start) begin
            // R9: a start pulse in mid-run
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (busy && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        chk(cyc == s + NB + leff + RW + 6, "R7", "idle cycle after unload",
            cyc, s + NB + leff + RW + 6);
        chk(fail == !e.pass, "R8", "flag after run", fail, !e.pass);
        repeat (5) @(negedge clk);
        chk(fail == !e.pass, "R8", "flag held in idle", fail, !e.pass);
        chk(busy == 1'b0, "R9", "no restart from mid-run start", busy, 0);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10
        chk(busy == 1'b0, "R10", "busy after reset", busy, 0);
        chk(tdata == '0, "R10", "test data after reset", tdata, 0);
        chk(tgl == 1'b0, "R10", "toggle after reset", tgl, 0);
        chk(so_valid == 1'b0 && so == 1'b0, "R10", "serial out after reset",
            {so_valid, so}, 0);
        chk(fail == 1'b0, "R10", "flag after reset", fail, 0);

        run_test(3, 8'h3C, cut_fn(8'h3C), 3, '0, 1'b0, "R5");
        run_test(3, 8'h3C, cut_fn(8'h3C) ^ 8'h01, 3, '0, 1'b0, "R7");
        run_test(2, 8'h42, cut_fn(8'h42), 2, '0, 1'b0, "R8");
        run_test(5, 8'hA7, cut_fn(8'hA7), 6, '0, 1'b0, "R5");
        run_test(1, 8'h11, cut_fn(8'h11), 1, '0, 1'b0, "R5");
        run_test(1, 8'h11, cut_fn(8'h11), 2, '0, 1'b0, "R5");
        // R6: zero latency field acts as one
        run_test(0, 8'h80, cut_fn(8'h80), 1, '0, 1'b0, "R6");
        run_test(0, 8'h80, cut_fn(8'h80), 2, '0, 1'b0, "R6");
        run_test(15, 8'hF0, cut_fn(8'hF0), 15, '0, 1'b0, "R5");
        run_test(15, 8'hF0, cut_fn(8'hF0), 16, '0, 1'b0, "R5");
        run_test(7, 8'h69, cut_fn(8'h69), 4, 8'h80, 1'b0, "R7");
        run_test(10, 8'h5E, cut_fn(8'h5E), 10, '0, 1'b1, "R9");
        run_test(4, 8'h01, cut_fn(8'h01), 4, '0, 1'b0, "R8");

        repeat (4) @(negedge clk);
        chk(sbq.size() == 0, "R7", "results outstanding", sbq.size(), 0);
        summary();
    end

endmodule